// File: doc/BRIEF.md
# Multi-Source Interrupt Level Encoder

This block sits between several interrupt sources and a 68000-style CPU. Each source request sets a sticky bit in a status register. The block then drives the three active-low priority lines with the single highest level among the pending bits. No source ever reaches the priority lines directly, so two overlapping requests can never merge into a false higher level. Software clears a status bit once it has serviced that source. Any bit left set keeps the interrupt asserted.

When the CPU runs an interrupt-acknowledge cycle, the block checks the acknowledged level against the pending sources. It answers with one of two responses, chosen per source by a parameter. One is an autovector request, in which case the CPU forms vector 24 plus the level. The other is a vector byte taken from a programmable register. That register comes out of reset holding 15, so an interrupt from a device that was never set up lands on a known default vector.

Top module: `irq_level_encoder`

## Requirements
- R1: A source whose request is high at a rising clock edge has its status bit set after that edge, and the bit stays set until software clears it.
- R2: A pulse on `clr_we` clears every status bit whose `clr_mask` bit is 1 (write-one-to-clear). If the same source requests in the same cycle, the set wins and the bit stays 1.
- R3: Default source-to-level mapping: source 0 is level 2 (general external request), source 1 is level 5 and source 2 is level 7.
- R4: `ipl_n` is the one's complement of the highest level among pending status bits, registered one cycle after the status register. With nothing pending it is 3'b111. Pending levels 2 and 5 together give 3'b010 (level 5), never 3'b000.
- R5: The priority lines stay active while any status bit is set. After the highest source is cleared, they fall back to the next pending level.
- R6: An acknowledge cycle is recognised only while `ack_strobe` is 1 and `fc` equals 3'b111. The acknowledged level arrives on `ack_level` (CPU address bits 3:1). Outside an acknowledge cycle, `vec_valid` and `avec_req` are both 0.
- R7: If the pending source at the acknowledged level is in autovector mode (default: source 0), the block raises `avec_req` and keeps `vec_valid` at 0.
- R8: If the pending source at the acknowledged level is in vectored mode (default: sources 1 and 2), the block raises `vec_valid` and drives `vec_out` with the vector register.
- R9: The vector register resets to 8'h0F and takes `vec_wdata` on a clock edge with `vec_we` high.
- R10: If no pending source sits at the acknowledged level, the block drives neither `vec_valid` nor `avec_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NUM_SRC | Interrupt requests, one per source |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | NUM_SRC | Status bits to clear (1 = clear) |
| vec_we | input | 1 | Vector register write strobe |
| vec_wdata | input | VEC_W | New vector register value |
| fc | input | 3 | CPU function code |
| ack_strobe | input | 1 | CPU cycle valid (address strobe) |
| ack_level | input | 3 | Acknowledged level (address bits 3:1) |
| status | output | NUM_SRC | Latched status register |
| ipl_n | output | 3 | Active-low priority level to the CPU |
| vec_out | output | VEC_W | Vector byte during acknowledge |
| vec_valid | output | 1 | Vector byte is being supplied |
| avec_req | output | 1 | Autovector requested |

## Verification
The bench raises levels 2 and 5 together. A design that ORed the sources onto the lines would show level 7 there. It also requests and clears the same bit in one cycle, where a design with the priority inverted would lose the interrupt. It acknowledges with the wrong function code and at a level with no pending source; a careless decoder would answer both. It checks the vector byte straight after reset, where a register that reset to zero would point the CPU at the stack-pointer slot. The random phase compares every cycle against a reference model of the status bits, the priority lines and the acknowledge response.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;

   localparam logic [2:0] FC_INT_ACK = 3'b111;

   typedef enum logic [1:0] {
      RESP_NONE = 2'd0,
      RESP_AUTO = 2'd1,
      RESP_VECT = 2'd2
   } resp_e;

   // pull one level field out of a packed per-source level table
   function automatic logic [2:0] level_of(input logic [63:0] table_bits, input int idx);
      logic [2:0] r;
      r = table_bits[idx*3 +: 3];
      return r;
   endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int NUM_SRC = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               clr_we,
   input  logic [NUM_SRC-1:0] clr_mask,
   output logic [NUM_SRC-1:0] status_q
);

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
         logic set_c;
         logic clr_c;

         assign set_c = src_req[g];
         assign clr_c = clr_we & clr_mask[g];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               status_q[g] <= 1'b0;
            end else if (set_c) begin
               status_q[g] <= 1'b1;
            end else if (clr_c) begin
               status_q[g] <= 1'b0;
            end
         end

         assert_req_latches_R1 : assert property (@(posedge clk) disable iff (!rst_n)
            src_req[g] |=> status_q[g]);

         assert_bit_sticky_R1 : assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[g] && !(clr_we && clr_mask[g])) |=> status_q[g]);

         assert_clear_works_R2 : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_mask[g] && !src_req[g]) |=> !status_q[g]);
      end
   endgenerate

endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder #(
   parameter int              NUM_SRC    = 3,
   parameter int              LVL_W      = 3,
   parameter logic [63:0]     SRC_LEVELS = 64'h1EA,
   parameter bit              REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] status_q,
   output logic [LVL_W-1:0]   ipl_n
);
   import irqenc_pkg::*;

   localparam logic [LVL_W-1:0] IDLE_LINES = '1;

   logic [LVL_W-1:0] top_level;

   // highest level among the pending bits; sources never combine their codes
   always_comb begin
      top_level = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (status_q[i] && (LVL_W'(level_of(SRC_LEVELS, i)) > top_level)) begin
            top_level = LVL_W'(level_of(SRC_LEVELS, i));
         end
      end
   end

   generate
      if (REGISTERED) begin : g_reg
         logic [LVL_W-1:0] ipl_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ipl_q <= IDLE_LINES;
            end else begin
               ipl_q <= ~top_level;
            end
         end

         assign ipl_n = ipl_q;

         assert_idle_lines_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            (status_q == '0) |=> (ipl_n == IDLE_LINES));

         assert_held_active_R5 : assert property (@(posedge clk) disable iff (!rst_n)
            (status_q != '0) |=> (ipl_n != IDLE_LINES));
      end else begin : g_comb
         assign ipl_n = ~top_level;

         always_comb begin
            if (rst_n) begin
               assert_comb_active_R5 : assert ((status_q == '0) == (ipl_n == IDLE_LINES));
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irq_vector_reg.sv
module irq_vector_reg #(
   parameter int               VEC_W     = 8,
   parameter logic [VEC_W-1:0] VEC_RESET = 8'h0F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vec_we,
   input  logic [VEC_W-1:0] vec_wdata,
   output logic [VEC_W-1:0] vec_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q <= VEC_RESET;
      end else if (vec_we) begin
         vec_q <= vec_wdata;
      end
   end

   assert_vec_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !vec_we |=> $stable(vec_q));

endmodule

// File: rtl/irq_ack_responder.sv
module irq_ack_responder #(
   parameter int              NUM_SRC    = 3,
   parameter int              LVL_W      = 3,
   parameter int              VEC_W      = 8,
   parameter logic [63:0]     SRC_LEVELS = 64'h1EA,
   parameter logic [NUM_SRC-1:0] AVEC_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] status_q,
   input  logic [VEC_W-1:0]   vec_q,
   input  logic [2:0]         fc,
   input  logic               ack_strobe,
   input  logic [LVL_W-1:0]   ack_level,
   output logic [VEC_W-1:0]   vec_out,
   output logic               vec_valid,
   output logic               avec_req
);
   import irqenc_pkg::*;

   logic         in_ack;
   logic [NUM_SRC-1:0] hit;
   resp_e        resp;

   assign in_ack = ack_strobe && (fc == FC_INT_ACK);

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
         assign hit[g] = status_q[g] && (LVL_W'(level_of(SRC_LEVELS, g)) == ack_level);
      end
   endgenerate

   // lowest-index pending source at the acknowledged level picks the mode
   always_comb begin
      resp = RESP_NONE;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (hit[i]) begin
            resp = AVEC_MASK[i] ? RESP_AUTO : RESP_VECT;
         end
      end
      if (!in_ack) begin
         resp = RESP_NONE;
      end
   end

   assign avec_req  = (resp == RESP_AUTO);
   assign vec_valid = (resp == RESP_VECT);
   assign vec_out   = vec_valid ? vec_q : '0;

   assert_one_answer_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({vec_valid, avec_req}));

   assert_quiet_outside_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_strobe && (fc == FC_INT_ACK)) |-> (!vec_valid && !avec_req));

   assert_no_pending_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (status_q == '0) |-> (!vec_valid && !avec_req));

endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder #(
   parameter int                 NUM_SRC        = 3,
   parameter int                 VEC_W          = 8,
   parameter logic [63:0]        SRC_LEVELS     = {55'd0, 3'd7, 3'd5, 3'd2},
   parameter logic [NUM_SRC-1:0] AVEC_MASK      = 3'b001,
   parameter logic [VEC_W-1:0]   VEC_RESET      = 8'h0F,
   parameter bit                 IPL_REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               clr_we,
   input  logic [NUM_SRC-1:0] clr_mask,
   input  logic               vec_we,
   input  logic [VEC_W-1:0]   vec_wdata,
   input  logic [2:0]         fc,
   input  logic               ack_strobe,
   input  logic [2:0]         ack_level,
   output logic [NUM_SRC-1:0] status,
   output logic [2:0]         ipl_n,
   output logic [VEC_W-1:0]   vec_out,
   output logic               vec_valid,
   output logic               avec_req
);
   import irqenc_pkg::*;

   localparam int LVL_W = 3;

   // elaboration-time parameter checks
   generate
      if (NUM_SRC < 1 || NUM_SRC > 21) begin : g_bad_count
         $error("irq_level_encoder: NUM_SRC must be 1..21");
      end
      if (VEC_W < 8) begin : g_bad_vec
         $error("irq_level_encoder: VEC_W must be at least 8");
      end
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl_chk
         if (SRC_LEVELS[g*3 +: 3] == 3'd0) begin : g_zero
            $error("irq_level_encoder: source level 0 is not a request");
         end
      end
   endgenerate

   logic [NUM_SRC-1:0] status_q;
   logic [VEC_W-1:0]   vec_q;

   irq_status_bank #(
      .NUM_SRC (NUM_SRC)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_req  (src_req),
      .clr_we   (clr_we),
      .clr_mask (clr_mask),
      .status_q (status_q)
   );

   irq_prio_encoder #(
      .NUM_SRC    (NUM_SRC),
      .LVL_W      (LVL_W),
      .SRC_LEVELS (SRC_LEVELS),
      .REGISTERED (IPL_REGISTERED)
   ) u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_q (status_q),
      .ipl_n    (ipl_n)
   );

   irq_vector_reg #(
      .VEC_W     (VEC_W),
      .VEC_RESET (VEC_RESET)
   ) u_vec (
      .clk       (clk),
      .rst_n     (rst_n),
      .vec_we    (vec_we),
      .vec_wdata (vec_wdata),
      .vec_q     (vec_q)
   );

   irq_ack_responder #(
      .NUM_SRC    (NUM_SRC),
      .LVL_W      (LVL_W),
      .VEC_W      (VEC_W),
      .SRC_LEVELS (SRC_LEVELS),
      .AVEC_MASK  (AVEC_MASK)
   ) u_ack (
      .clk        (clk),
      .rst_n      (rst_n),
      .status_q   (status_q),
      .vec_q      (vec_q),
      .fc         (fc),
      .ack_strobe (ack_strobe),
      .ack_level  (ack_level),
      .vec_out    (vec_out),
      .vec_valid  (vec_valid),
      .avec_req   (avec_req)
   );

   assign status = status_q;

endmodule

// File: tb/test_irq_level_encoder.sv
module test_irq_level_encoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] src_req = '0;
   logic       clr_we = 1'b0;
   logic [2:0] clr_mask = '0;
   logic       vec_we = 1'b0;
   logic [7:0] vec_wdata = '0;
   logic [2:0] fc = '0;
   logic       ack_strobe = 1'b0;
   logic [2:0] ack_level = '0;
   logic [2:0] status;
   logic [2:0] ipl_n;
   logic [7:0] vec_out;
   logic       vec_valid;
   logic       avec_req;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [2:0] exp_st = '0;
   logic [7:0] exp_vec = 8'h0F;

   always #2.5 clk = ~clk;

   irq_level_encoder i_irq_level_encoder (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .clr_we(clr_we),
      .clr_mask(clr_mask), .vec_we(vec_we), .vec_wdata(vec_wdata), .fc(fc),
      .ack_strobe(ack_strobe), .ack_level(ack_level), .status(status),
      .ipl_n(ipl_n), .vec_out(vec_out), .vec_valid(vec_valid), .avec_req(avec_req)
   );

   // R3: fixed mapping of source index to level
   function automatic logic [2:0] src_lvl(input int i);
      case (i)
         0: return 3'd2;
         1: return 3'd5;
         default: return 3'd7;
      endcase
   endfunction

   function automatic logic [2:0] exp_ipl(input logic [2:0] st);
      logic [2:0] m;
      m = 3'd0;
      for (int i = 0; i < 3; i++) if (st[i] && src_lvl(i) > m) m = src_lvl(i);
      return ~m;
   endfunction

   // returns {avec, vvalid}
   function automatic logic [1:0] exp_resp(input logic [2:0] st, input logic s,
                                           input logic [2:0] f, input logic [2:0] al);
      if (!(s && f == 3'b111)) return 2'b00;
      for (int i = 0; i < 3; i++) begin
         if (st[i] && src_lvl(i) == al) return (i == 0) ? 2'b10 : 2'b01;
      end
      return 2'b00;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_ack();
      logic [1:0] e;
      string tag;
      e = exp_resp(exp_st, ack_strobe, fc, ack_level);
      if (!(ack_strobe && fc == 3'b111)) tag = "R6";
      else if (e == 2'b10) tag = "R7";
      else if (e == 2'b01) tag = "R8";
      else tag = "R10";
      check({tag, " response"}, {30'd0, avec_req, vec_valid}, {30'd0, e});
      if (e == 2'b01) check("R8/R9 vector byte", {24'd0, vec_out}, {24'd0, exp_vec});
   endtask

   // called just after a falling edge
   task automatic step(input logic [2:0] rq, input logic cw, input logic [2:0] cm,
                       input logic vw, input logic [7:0] vd,
                       input logic [2:0] f, input logic s, input logic [2:0] al);
      logic [2:0] prev;
      src_req = rq; clr_we = cw; clr_mask = cm; vec_we = vw; vec_wdata = vd;
      fc = f; ack_strobe = s; ack_level = al;
      #1;
      check_ack();
      prev = exp_st;
      @(posedge clk);
      for (int i = 0; i < 3; i++) begin
         if (rq[i]) exp_st[i] = 1'b1;
         else if (cw && cm[i]) exp_st[i] = 1'b0;
      end
      if (vw) exp_vec = vd;
      @(negedge clk);
      check("R1/R2 status", {29'd0, status}, {29'd0, exp_st});
      check("R4 ipl_n", {29'd0, ipl_n}, {29'd0, exp_ipl(prev)});
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R1 reset status", {29'd0, status}, 32'd0);
      check("R4 reset ipl_n", {29'd0, ipl_n}, 32'h7);
      rst_n = 1'b1;

      // R9: default vector right after reset, via a vectored level-5 source
      step(3'b010, 0, 0, 0, 0, 3'b000, 0, 0);
      step(3'b000, 0, 0, 0, 0, 3'b111, 1, 3'd5);
      check("R9 reset vector", {24'd0, vec_out}, 32'h0F);
      check("R4 level 5 lines", {29'd0, ipl_n}, 32'h2);

      // R4/R3: overlap of levels 2 and 5 must give 5, not 7
      step(3'b001, 0, 0, 0, 0, 3'b000, 0, 0);
      step(3'b000, 0, 0, 0, 0, 3'b111, 1, 3'd2);
      check("R7 autovector level 2", {31'd0, avec_req}, 32'd1);
      check("R4 overlap 2+5", {29'd0, ipl_n}, 32'h2);

      // R6: wrong function code ignored
      step(3'b000, 0, 0, 0, 0, 3'b110, 1, 3'd5);
      // R10: nothing pending at level 7
      step(3'b000, 0, 0, 0, 0, 3'b111, 1, 3'd7);

      // R5: clear level 5, lines fall back to level 2
      step(3'b000, 1, 3'b010, 0, 0, 3'b000, 0, 0);
      step(3'b000, 0, 0, 0, 0, 3'b000, 0, 0);
      check("R5 fallback to level 2", {29'd0, ipl_n}, 32'h5);

      // R2: set wins over clear in the same cycle
      step(3'b001, 1, 3'b001, 0, 0, 3'b000, 0, 0);
      check("R2 set wins", {31'd0, status[0]}, 32'd1);

      // R9: write a vector, then level 7 vectored answer
      step(3'b100, 0, 0, 1, 8'h64, 3'b000, 0, 0);
      step(3'b000, 0, 0, 0, 0, 3'b111, 1, 3'd7);
      check("R8 level 7 vector", {24'd0, vec_out}, 32'h64);
      check("R3 level 7 lines", {29'd0, ipl_n}, 32'h0);

      // R5: clear all, lines go idle
      step(3'b000, 1, 3'b111, 0, 0, 3'b000, 0, 0);
      step(3'b000, 0, 0, 0, 0, 3'b000, 0, 0);
      check("R5 idle after clear", {29'd0, ipl_n}, 32'h7);

      // random phase
      for (int n = 0; n < 400; n++) begin
         logic [2:0] rq;
         logic [2:0] al;
         logic [2:0] f;
         int pick;
         rq = 3'($urandom) & 3'($urandom) & 3'($urandom);
         pick = int'($urandom % 4);
         al = (pick == 0) ? 3'd2 : (pick == 1) ? 3'd5 : (pick == 2) ? 3'd7 : 3'($urandom);
         f = ($urandom % 4 != 0) ? 3'b111 : 3'($urandom);
         step(rq, 1'($urandom % 3 == 0), 3'($urandom), 1'($urandom % 10 == 0),
              8'($urandom), f, 1'($urandom % 4 != 0), al);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule